// File: doc/BRIEF.md
# Byte-Wide ADC Readout Sequencer

This block runs a 12-bit sampling converter from the host side when the converter presents its result on an 8-bit parallel bus. When it receives a start request it drives an active-low convert pulse of a set width. It then follows the converter's busy line through a two-flop synchronizer. Busy first falls and later rises. On the synchronized rising edge the block captures the upper eight result bits while the byte-select line is low. It then raises byte-select, waits a settle interval, and captures the four low bits.

The two bytes are joined into the 12-bit two's complement sample. That sample is sign-extended to 16 bits and presented with a one-cycle valid strobe. The block also enforces a minimum number of cycles between successive convert pulses, so the converter has time to acquire the next input. A start request that arrives while the block is busy or inside that interval is held, and it is served once the block is free.

Top module: `adc_byte_reader`

## Requirements
- R1: While reset is asserted and right after it, the convert output is high, byte-select is low, the valid strobe is low and the result is zero.
- R2: Each convert pulse holds the convert output low for exactly PULSE_CYC clock cycles.
- R3: A convert pulse never begins while the synchronized busy input is low. After a pulse, the block waits for synchronized busy to fall and then to rise before it reads.
- R4: The first capture happens on the synchronized rising edge of busy with byte-select low. data_i[7:0] then holds sample bits 11 to 4.
- R5: After the first capture, byte-select is high for exactly SETTLE_CYC cycles. At the end of that time, data_i[7:4] is taken as sample bits 3 to 0, and data_i[3:0] has no effect on the result.
- R6: The result is the 12-bit two's complement sample sign-extended to 16 bits (bit 11 copied into bits 15 to 12). The valid strobe is high for exactly one cycle per conversion.
- R7: The falling edges of two successive convert pulses are at least GAP_CYC clock cycles apart.
- R8: A start request seen while a conversion or the spacing interval is in progress is held and served once. Several such requests collapse into a single extra conversion.
- R9: Byte-select returns low in the same cycle in which the valid strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request for one conversion |
| conv_n_o | output | 1 | Convert pulse to the converter, active low |
| byte_sel_o | output | 1 | Byte select: low selects the high byte, high selects the low nibble |
| busy_i | input | 1 | Converter busy, low while a conversion runs (asynchronous) |
| data_i | input | 8 | Converter parallel data bus |
| result_o | output | 16 | Sign-extended sample |
| result_valid_o | output | 1 | One-cycle strobe for result_o |

## Verification
The samples cover zero, the most positive code 0x7FF, the most negative code 0x800, all-ones 0xFFF, and two mixed patterns. Together these show whether the sign extension follows bit 11, and whether the high byte and the low nibble are placed in the right positions. While byte-select is high, the converter model drives the inverse of the expected pattern on the unused low four data lines, so any leak from those lines changes the result. Conversions are requested back to back, which separates the spacing limit from the conversion time. Extra start requests are raised during a running conversion to show that they are held and merged into one.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT_LOW,
    ST_WAIT_HIGH,
    ST_SETTLE
  } rd_state_t;

  // Join the high byte and the low nibble, then sign-extend bit 11 to 16 bits.
  function automatic logic [15:0] widen_sample(input logic [7:0] hi_byte,
                                               input logic [3:0] lo_nib);
    return {{4{hi_byte[7]}}, hi_byte, lo_nib};
  endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_s,
  output logic busy_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= busy_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign busy_s    = sync_q;
  assign busy_rise = sync_q & ~prev_q;
endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= value;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
  import adc_rd_pkg::*;
#(
  parameter int PULSE_CYC  = 4,
  parameter int SETTLE_CYC = 2,
  parameter int GAP_CYC    = 2500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        conv_n_o,
  output logic        byte_sel_o,
  input  logic        busy_i,
  input  logic [7:0]  data_i,
  output logic [15:0] result_o,
  output logic        result_valid_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  rd_state_t  state_q;
  logic       pending_q;
  logic [7:0] hi_q;
  logic       busy_s, busy_rise;
  logic       pulse_done, settle_done, gap_done;

  // named events used by the sequencer and by the assertions
  logic launch, read_hi, read_lo;
  assign launch  = (state_q == ST_IDLE) && (start_i || pending_q) && gap_done && busy_s;
  assign read_hi = (state_q == ST_WAIT_HIGH) && busy_rise;
  assign read_lo = (state_q == ST_SETTLE) && settle_done;

  adc_busy_sync u_sync (
    .clk(clk), .rst_n(rst_n), .busy_async(busy_i),
    .busy_s(busy_s), .busy_rise(busy_rise)
  );

  adc_cycle_timer #(.W(PW)) u_pulse_tmr (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .value(PW'(PULSE_CYC - 1)), .done(pulse_done)
  );

  adc_cycle_timer #(.W(SW)) u_settle_tmr (
    .clk(clk), .rst_n(rst_n), .load(read_hi),
    .value(SW'(SETTLE_CYC - 1)), .done(settle_done)
  );

  adc_cycle_timer #(.W(GW)) u_gap_tmr (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .value(GW'(GAP_CYC - 1)), .done(gap_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      pending_q      <= 1'b0;
      hi_q           <= '0;
      byte_sel_o     <= 1'b0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
    end else begin
      result_valid_o <= 1'b0;
      if (launch)       pending_q <= 1'b0;
      else if (start_i) pending_q <= 1'b1;
      unique case (state_q)
        ST_IDLE:      if (launch) state_q <= ST_PULSE;
        ST_PULSE:     if (pulse_done) state_q <= ST_WAIT_LOW;
        ST_WAIT_LOW:  if (!busy_s) state_q <= ST_WAIT_HIGH;
        ST_WAIT_HIGH: if (read_hi) begin
                        hi_q       <= data_i;
                        byte_sel_o <= 1'b1;
                        state_q    <= ST_SETTLE;
                      end
        ST_SETTLE:    if (read_lo) begin
                        result_o       <= widen_sample(hi_q, data_i[7:4]);
                        result_valid_o <= 1'b1;
                        byte_sel_o     <= 1'b0;
                        state_q        <= ST_IDLE;
                      end
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_n_o = (state_q != ST_PULSE);

  // ---------------- assertions ----------------
  // cycles since the last convert falling edge, saturating at GAP_CYC
  logic [GW-1:0] since_fall_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                        since_fall_q <= GW'(GAP_CYC);
    else if (launch)                   since_fall_q <= '0;
    else if (since_fall_q != GW'(GAP_CYC)) since_fall_q <= since_fall_q + 1'b1;
  end

  assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (since_fall_q >= GW'(GAP_CYC - 1)));

  assert_no_conv_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n_o) |-> $past(busy_s));

  assert_hi_byte_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    read_hi |-> !byte_sel_o);

  assert_lo_byte_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    read_lo |-> byte_sel_o);

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);

  assert_select_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid_o) |-> !byte_sel_o);
endmodule

// File: tb/adc_byte_reader_test.sv
module adc_byte_reader_test;
  localparam int PULSE  = 4;
  localparam int SETTLE = 3;
  localparam int GAP    = 60;
  localparam int LAT    = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy = 1'b1;
  logic [11:0] cur = 12'h000;
  logic        conv_n, byte_sel, valid;
  logic [7:0]  data;
  logic [15:0] result;

  int errors = 0;
  int checks = 0;
  int conv_count = 0;
  logic [11:0] adc_q[$];
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  // converter bus: low nibble lines carry the inverse pattern while ignored
  assign data = byte_sel ? {cur[3:0], ~cur[3:0]} : cur[11:4];

  adc_byte_reader #(.PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .conv_n_o(conv_n),
    .byte_sel_o(byte_sel), .busy_i(busy), .data_i(data),
    .result_o(result), .result_valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // expected value computed as a signed integer, then truncated to 16 bits
  function automatic logic [15:0] expect_of(input logic [11:0] s);
    int v;
    v = int'(s);
    if (v >= 2048) v = v - 4096;
    return 16'(v);
  endfunction

  task automatic push_sample(input logic [11:0] s);
    adc_q.push_back(s);
    exp_q.push_back(expect_of(s));
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // converter model
  initial begin
    forever begin
      logic [11:0] s;
      @(negedge conv_n);
      s = (adc_q.size() != 0) ? adc_q.pop_front() : 12'h000;
      @(posedge clk); #1 busy = 1'b0;
      repeat (LAT) @(posedge clk);
      #1 cur = s;
      busy = 1'b1;
    end
  end

  // monitor and scoreboard
  initial begin
    logic prev_conv = 1'b1, prev_busy = 1'b1, prev_valid = 1'b0, prev_sel = 1'b0;
    int cyc = 0, last_fall = -1, low_run = 0, sel_run = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (prev_conv && !conv_n) begin
          conv_count++;
          check(busy == 1'b1, "R3 busy high at convert", 32'(busy), 32'd1);
          if (last_fall >= 0)
            check(cyc - last_fall >= GAP, "R7 convert spacing", 32'(cyc - last_fall), 32'(GAP));
          last_fall = cyc;
        end
        if (!conv_n) low_run++;
        if (!prev_conv && conv_n) begin
          check(low_run == PULSE, "R2 pulse width", 32'(low_run), 32'(PULSE));
          low_run = 0;
        end
        if (!prev_busy && busy)
          check(byte_sel == 1'b0, "R4 select low at busy rise", 32'(byte_sel), 32'd0);
        if (byte_sel) sel_run++;
        if (prev_sel && !byte_sel) begin
          check(sel_run == SETTLE, "R5 settle length", 32'(sel_run), 32'(SETTLE));
          sel_run = 0;
        end
        if (valid) begin
          logic [15:0] e;
          e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'hxxxx;
          check(result === e, "R6 R4 R5 result", 32'(result), 32'(e));
          check(byte_sel == 1'b0, "R9 select released", 32'(byte_sel), 32'd0);
        end
        if (prev_valid && valid)
          check(1'b0, "R6 strobe longer than one cycle", 32'd1, 32'd0);
      end
      prev_conv  = conv_n;
      prev_busy  = busy;
      prev_valid = valid;
      prev_sel   = byte_sel;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(conv_n == 1'b1, "R1 convert idle", 32'(conv_n), 32'd1);
    check(byte_sel == 1'b0, "R1 select idle", 32'(byte_sel), 32'd0);
    check(valid == 1'b0, "R1 strobe idle", 32'(valid), 32'd0);
    check(result == 16'h0, "R1 result cleared", 32'(result), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(conv_n == 1'b1 && valid == 1'b0, "R1 after reset", {conv_n, valid}, 2'b10);

    // back-to-back singles; each start right after the previous result
    foreach (sample_list[i]) begin
      push_sample(sample_list[i]);
      pulse_start();
      drain();
    end

    // held request: two extra starts during a running conversion give one more
    push_sample(12'h3C0);
    push_sample(12'hC3A);
    pulse_start();
    while (busy) @(negedge clk);
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    drain();
    repeat (3 * GAP) @(negedge clk);
    check(conv_count == 8, "R8 held start served once", 32'(conv_count), 32'd8);
    check(exp_q.size() == 0, "R8 all results seen", 32'(exp_q.size()), 32'd0);
    report();
  end

  logic [11:0] sample_list [6] = '{12'h000, 12'h7FF, 12'h800, 12'hFFF, 12'h123, 12'hA5C};
endmodule